// File: doc/BRIEF.md
# Sensor Register Bus Slave

This block connects a small temperature-sensor register file to a two-wire serial bus. A fast system clock samples the bus clock and data lines, finds start and stop conditions, and shifts bytes in and out. The slave answers one 7-bit device address and pulls the data line low to acknowledge. Three bits of that address come from pins, and a parameter can fix them at zero with a different upper nibble. The first byte after an accepted write address sets a register pointer. Further bytes write the selected register. A read returns the register the pointer last selected.

The register file holds a read-only 16-bit temperature value, an 8-bit configuration register and two 16-bit limit registers (over-temperature and hysteresis). While the device is part of a bus transaction, an output tells the sensor core to abandon its conversion. After the closing stop, a one-cycle pulse tells it to start over. The pad output is a single "pull low" request, and an external open-drain driver turns it into a line level.

Top module: `tsense_bus_slave`

## Requirements
- R1: After reset the slave does not pull the data line, convAbort and convRestart are low, the configuration register is 0x00, the over-temperature limit is 0x5000 and the hysteresis limit is 0x4B00.
- R2: When the 7 address bits after a start (MSB first, followed by the direction bit, 0 = write and 1 = read) equal 1001 followed by addrPins[2:0], the slave pulls the data line low during the ninth clock pulse of that byte.
- R3: For any other address the slave never pulls the data line until the next start, and no register changes.
- R4: A write made of the address byte and a single pointer byte changes no data register. It only selects the register that later reads return. Pointer codes are 0 temperature, 1 configuration, 2 hysteresis, 3 over-temperature.
- R5: A write to the configuration register takes the first data byte, and any further data byte is ignored.
- R6: A single data byte written to a limit register replaces its high byte and leaves its low byte unchanged.
- R7: Two data bytes written to a limit register load the high byte and then the low byte.
- R8: A read sends the selected register MSB first. For a 16-bit register the high byte comes first, and the low byte follows only if the master acknowledged the high byte. The configuration register reads as one byte.
- R9: After the master leaves the acknowledge bit of a read byte high, the slave releases the data line.
- R10: Pointer values above 3 read as zero, and data bytes written to them change nothing.
- R11: convAbort rises when the device address is accepted and stays high until the stop. convRestart pulses for exactly one cycle at that stop and only then.
- R12: A start that arrives in the middle of a byte restarts bit and byte counting, and the transaction that follows works normally.
- R13: The slave changes its data-line drive only while the sampled bus clock is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| addrPins | input | 3 | Low three bits of the device address |
| tempValue | input | 16 | Latest temperature result from the sensor core |
| sdaPullLow | output | 1 | 1 requests the pad to pull the data line low |
| cfgReg | output | 8 | Configuration register |
| hotLimit | output | 16 | Over-temperature limit register |
| hystLimit | output | 16 | Hysteresis limit register |
| convAbort | output | 1 | High while the device takes part in a transaction |
| convRestart | output | 1 | One-cycle pulse after the stop that ends such a transaction |

## Verification
Assertions check the following on every cycle:
- the data-line drive changes only while the sampled bus clock is low;
- an idle slave never pulls the line;
- outside a read, an acknowledge drive appears only in the ninth bit slot;
- a restart pulse lasts one cycle and follows an abort;
- a pointer-only write, a write to an unused pointer, a surplus configuration byte or a one-byte limit write leaves the protected bits unchanged.

Only the bench's scenarios can show that the address compare accepts exactly one of all 128 addresses, that the bytes read back carry the right values in the right order, that a negative acknowledge ends a read, and that a start in the middle of a byte recovers cleanly.

// File: rtl/tsbus_pkg.sv
package tsbus_pkg;
  localparam int PTR_W = 8;

  localparam logic [PTR_W-1:0] SEL_TEMP = 8'd0;
  localparam logic [PTR_W-1:0] SEL_CFG  = 8'd1;
  localparam logic [PTR_W-1:0] SEL_HYST = 8'd2;
  localparam logic [PTR_W-1:0] SEL_HOT  = 8'd3;

  typedef struct packed {
    logic       ptrWr;    // byte loads the register pointer
    logic       dataWr;   // byte is data for the selected register
    logic       dataLow;  // data byte is the second (low) byte
    logic [7:0] wrByte;
  } busStrb_t;

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_WR, ST_RD} busState_t;
endpackage

// File: rtl/tsbus_ctrl.sv
module tsbus_ctrl
  import tsbus_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] ADDR_HI     = 4'b1001,
  parameter bit         USE_PINS    = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] addrPins,
  input  logic [7:0] rdHi,
  input  logic [7:0] rdLo,
  input  logic       rdIs16,
  output busStrb_t   strb,
  output logic       sdaLow,
  output logic       convAbort,
  output logic       convRestart
);
  localparam logic [3:0] BIT_FULL = 4'd8;
  localparam logic [3:0] BIT_LAST = 4'd7;

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;

  // bus line synchronisers, one flop per stage
  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) begin
            sclPipe[0] <= 1'b1;
            sdaPipe[0] <= 1'b1;
          end else begin
            sclPipe[0] <= sclIn;
            sdaPipe[0] <= sdaIn;
          end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) begin
            sclPipe[g] <= 1'b1;
            sdaPipe[g] <= 1'b1;
          end else begin
            sclPipe[g] <= sclPipe[g-1];
            sdaPipe[g] <= sdaPipe[g-1];
          end
      end
    end
  endgenerate

  logic sclSync, sdaSync, sclPrev, sdaPrev;
  assign sclSync = sclPipe[SYNC_STAGES-1];
  assign sdaSync = sdaPipe[SYNC_STAGES-1];

  logic startDet, stopDet, sclRise, sclFall;
  assign startDet = sclSync && sclPrev && sdaPrev && !sdaSync;
  assign stopDet  = sclSync && sclPrev && !sdaPrev && sdaSync;
  assign sclRise  = sclSync && !sclPrev;
  assign sclFall  = !sclSync && sclPrev;

  logic [6:0] devAddr;
  assign devAddr = {ADDR_HI, (USE_PINS ? addrPins : 3'b000)};

  busState_t  state;
  logic [3:0] bitCnt;
  logic       inAck, ackThis, masterAck, firstRd, nextLow, sessAddr;
  logic [6:0] shiftR;
  logic [1:0] wrIdx;
  logic [7:0] txByte;
  logic [7:0] byteIn, txNext;

  assign byteIn    = {shiftR, sdaSync};
  assign txNext    = nextLow ? rdLo : rdHi;
  assign convAbort = sessAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev     <= 1'b1;
      sdaPrev     <= 1'b1;
      state       <= ST_IDLE;
      bitCnt      <= '0;
      inAck       <= 1'b0;
      ackThis     <= 1'b0;
      masterAck   <= 1'b0;
      firstRd     <= 1'b0;
      nextLow     <= 1'b0;
      sessAddr    <= 1'b0;
      shiftR      <= '0;
      wrIdx       <= '0;
      txByte      <= '0;
      sdaLow      <= 1'b0;
      strb        <= '0;
      convRestart <= 1'b0;
    end else begin
      sclPrev     <= sclSync;
      sdaPrev     <= sdaSync;
      strb        <= '0;
      convRestart <= 1'b0;
      if (startDet) begin
        state  <= ST_ADDR;
        bitCnt <= '0;
        inAck  <= 1'b0;
        wrIdx  <= '0;
        sdaLow <= 1'b0;
      end else if (stopDet) begin
        state  <= ST_IDLE;
        sdaLow <= 1'b0;
        if (sessAddr) convRestart <= 1'b1;
        sessAddr <= 1'b0;
      end else if (state != ST_IDLE) begin
        if (sclRise) begin
          if (!inAck && bitCnt != BIT_FULL) begin
            shiftR <= byteIn[6:0];
            bitCnt <= bitCnt + 4'd1;
            if (bitCnt == BIT_LAST) begin
              unique case (state)
                ST_ADDR: begin
                  if (byteIn[7:1] == devAddr) begin
                    ackThis  <= 1'b1;
                    sessAddr <= 1'b1;
                    firstRd  <= 1'b1;
                    nextLow  <= 1'b0;
                    state    <= byteIn[0] ? ST_RD : ST_WR;
                  end else begin
                    ackThis <= 1'b0;
                    state   <= ST_IDLE;
                  end
                end
                ST_WR: begin
                  ackThis     <= 1'b1;
                  strb.wrByte <= byteIn;
                  if (wrIdx == 2'd0) strb.ptrWr <= 1'b1;
                  else if (wrIdx != 2'd3) begin
                    strb.dataWr  <= 1'b1;
                    strb.dataLow <= (wrIdx == 2'd2);
                  end
                  if (wrIdx != 2'd3) wrIdx <= wrIdx + 2'd1;
                end
                default: ackThis <= 1'b0;
              endcase
            end
          end else if (!inAck) begin
            inAck     <= 1'b1;
            masterAck <= !sdaSync;
          end
        end
        if (sclFall) begin
          if (bitCnt == BIT_FULL && !inAck) begin
            sdaLow <= ackThis;
          end else if (inAck) begin
            inAck  <= 1'b0;
            bitCnt <= '0;
            sdaLow <= 1'b0;
            if (state == ST_RD) begin
              if (firstRd || masterAck) begin
                txByte  <= {txNext[6:0], 1'b0};
                sdaLow  <= !txNext[7];
                nextLow <= rdIs16 && !nextLow;
                firstRd <= 1'b0;
              end else begin
                state <= ST_IDLE;
              end
            end
          end else if (state == ST_RD && bitCnt != 4'd0) begin
            sdaLow <= !txByte[7];
            txByte <= {txByte[6:0], 1'b0};
          end
        end
      end
    end
  end

  p_sda_scl_low_r13: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaLow) |-> !sclSync);
  p_idle_release_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !sdaLow);
  p_ack_slot_r2: assert property (@(posedge clk) disable iff (!rstN)
    (sdaLow && state != ST_RD) |-> (bitCnt == BIT_FULL));
  p_restart_after_abort_r11: assert property (@(posedge clk) disable iff (!rstN)
    convRestart |-> $past(convAbort));
  p_restart_single_r11: assert property (@(posedge clk) disable iff (!rstN)
    convRestart |=> !convRestart);
endmodule

// File: rtl/tsbus_regs.sv
module tsbus_regs
  import tsbus_pkg::*;
#(
  parameter logic [7:0]  CFG_RST  = 8'h00,
  parameter logic [15:0] HOT_RST  = 16'h5000,
  parameter logic [15:0] HYST_RST = 16'h4B00
) (
  input  logic        clk,
  input  logic        rstN,
  input  busStrb_t    strb,
  input  logic [15:0] tempValue,
  output logic [7:0]  cfgReg,
  output logic [15:0] hotLimit,
  output logic [15:0] hystLimit,
  output logic [7:0]  rdHi,
  output logic [7:0]  rdLo,
  output logic        rdIs16
);
  logic [PTR_W-1:0] regSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regSel    <= SEL_TEMP;
      cfgReg    <= CFG_RST;
      hotLimit  <= HOT_RST;
      hystLimit <= HYST_RST;
    end else begin
      if (strb.ptrWr) regSel <= strb.wrByte;
      if (strb.dataWr) begin
        unique case (regSel)
          SEL_CFG:  if (!strb.dataLow) cfgReg <= strb.wrByte;
          SEL_HYST: if (strb.dataLow) hystLimit[7:0] <= strb.wrByte;
                    else              hystLimit[15:8] <= strb.wrByte;
          SEL_HOT:  if (strb.dataLow) hotLimit[7:0] <= strb.wrByte;
                    else              hotLimit[15:8] <= strb.wrByte;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdHi   = 8'h00;
    rdLo   = 8'h00;
    rdIs16 = 1'b0;
    unique case (regSel)
      SEL_TEMP: begin rdHi = tempValue[15:8]; rdLo = tempValue[7:0]; rdIs16 = 1'b1; end
      SEL_CFG:  rdHi = cfgReg;
      SEL_HYST: begin rdHi = hystLimit[15:8]; rdLo = hystLimit[7:0]; rdIs16 = 1'b1; end
      SEL_HOT:  begin rdHi = hotLimit[15:8];  rdLo = hotLimit[7:0];  rdIs16 = 1'b1; end
      default: ;
    endcase
  end

  p_ptr_only_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.ptrWr |=> ($stable(cfgReg) && $stable(hotLimit) && $stable(hystLimit)));
  p_cfg_extra_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dataWr && strb.dataLow) |=> $stable(cfgReg));
  p_msb_only_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dataWr && !strb.dataLow) |=> ($stable(hotLimit[7:0]) && $stable(hystLimit[7:0])));
  p_unused_sel_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dataWr && regSel > SEL_HOT) |=> ($stable(cfgReg) && $stable(hotLimit) && $stable(hystLimit)));
endmodule

// File: rtl/tsense_bus_slave.sv
module tsense_bus_slave
  import tsbus_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter logic [3:0]  ADDR_HI     = 4'b1001,
  parameter bit          USE_PINS    = 1'b1,
  parameter logic [7:0]  CFG_RST     = 8'h00,
  parameter logic [15:0] HOT_RST     = 16'h5000,
  parameter logic [15:0] HYST_RST    = 16'h4B00
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  logic [2:0]  addrPins,
  input  logic [15:0] tempValue,
  output logic        sdaPullLow,
  output logic [7:0]  cfgReg,
  output logic [15:0] hotLimit,
  output logic [15:0] hystLimit,
  output logic        convAbort,
  output logic        convRestart
);
  busStrb_t   strb;
  logic [7:0] rdHi, rdLo;
  logic       rdIs16;

  tsbus_ctrl #(
    .SYNC_STAGES(SYNC_STAGES), .ADDR_HI(ADDR_HI), .USE_PINS(USE_PINS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .addrPins(addrPins),
    .rdHi(rdHi), .rdLo(rdLo), .rdIs16(rdIs16), .strb(strb),
    .sdaLow(sdaPullLow), .convAbort(convAbort), .convRestart(convRestart)
  );

  tsbus_regs #(
    .CFG_RST(CFG_RST), .HOT_RST(HOT_RST), .HYST_RST(HYST_RST)
  ) u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .tempValue(tempValue),
    .cfgReg(cfgReg), .hotLimit(hotLimit), .hystLimit(hystLimit),
    .rdHi(rdHi), .rdLo(rdLo), .rdIs16(rdIs16)
  );
endmodule

// File: tb/tsense_bus_slave_tb.sv
module tsense_bus_slave_tb;
  localparam int Q = 6;
  localparam logic [2:0] PINS = 3'b101;
  localparam logic [6:0] DEV = {4'b1001, PINS};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic sdaLine;
  logic [15:0] tempValue = 16'h1A80;
  logic sdaPullLow, convAbort, convRestart;
  logic [7:0] cfgReg;
  logic [15:0] hotLimit, hystLimit;
  int nChk = 0, nFail = 0, restartCnt = 0;

  always #2 clk = ~clk;
  assign sdaLine = sdaM & ~sdaPullLow;

  tsense_bus_slave u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .addrPins(PINS),
    .tempValue(tempValue), .sdaPullLow(sdaPullLow), .cfgReg(cfgReg),
    .hotLimit(hotLimit), .hystLimit(hystLimit), .convAbort(convAbort),
    .convRestart(convRestart)
  );

  always @(posedge clk) if (rstN && convRestart) restartCnt++;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ(); sdaM = 1'b0; waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ(); sclM = 1'b1; waitQ(); sdaM = 1'b1; waitQ();
  endtask

  task automatic clkBit(input logic b, output logic seen);
    sdaM = b; waitQ(); sclM = 1'b1; waitQ(); seen = sdaLine; waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clkBit(b[i], s);
    clkBit(1'b1, s);
    ack = !s;
  endtask

  task automatic recvByte(input logic ackIt, output logic [7:0] b, output logic relAfter);
    logic s;
    for (int i = 7; i >= 0; i--) begin clkBit(1'b1, s); b[i] = s; end
    clkBit(!ackIt, s);
    relAfter = !sdaPullLow;
  endtask

  task automatic writeRegs(input string tag, input logic [7:0] ptr, input int n,
                           input logic [7:0] d0, input logic [7:0] d1);
    logic ack;
    busStart();
    sendByte({DEV, 1'b0}, ack); chk({tag, " addr ack"}, 16'(ack), 16'd1);
    sendByte(ptr, ack);         chk({tag, " ptr ack"}, 16'(ack), 16'd1);
    if (n > 0) begin sendByte(d0, ack); chk({tag, " d0 ack"}, 16'(ack), 16'd1); end
    if (n > 1) begin sendByte(d1, ack); chk({tag, " d1 ack"}, 16'(ack), 16'd1); end
    busStop();
  endtask

  task automatic readRegs(input string tag, input int n, output logic [15:0] v);
    logic ack, rel;
    logic [7:0] b;
    v = '0;
    busStart();
    sendByte({DEV, 1'b1}, ack); chk({tag, " rd addr ack"}, 16'(ack), 16'd1);
    for (int k = 0; k < n; k++) begin
      recvByte(k != n - 1, b, rel);
      v = {v[7:0], b};
    end
    chk({tag, " R9 release after nack"}, 16'(rel), 16'd1);
    busStop();
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    logic ack;
    logic s;
    logic [7:0] expCfg;
    logic [15:0] v;
    int rBefore;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk("R1 sdaPullLow", 16'(sdaPullLow), 16'd0);
    chk("R1 cfgReg", 16'(cfgReg), 16'h0000);
    chk("R1 hotLimit", hotLimit, 16'h5000);
    chk("R1 hystLimit", hystLimit, 16'h4B00);
    chk("R1 convAbort", 16'(convAbort), 16'd0);
    chk("R1 convRestart", 16'(convRestart), 16'd0);

    // R2 / R3 / R11: sweep every 7-bit address
    expCfg = 8'h00;
    for (int a = 0; a < 128; a++) begin
      logic hit;
      hit = (7'(a) == DEV);
      rBefore = restartCnt;
      busStart();
      sendByte({7'(a), 1'b0}, ack);
      chk(hit ? "R2 ack on match" : "R3 no ack on mismatch", 16'(ack), 16'(hit));
      chk("R11 convAbort after address", 16'(convAbort), 16'(hit));
      if (hit) begin
        sendByte(8'h01, ack);
        sendByte(8'h5A, ack);
        expCfg = 8'h5A;
      end else begin
        sendByte(8'h00, ack);
        chk("R3 data line released", 16'(ack), 16'd0);
      end
      busStop();
      repeat (4) @(negedge clk);
      chk("R3 cfg only on match", 16'(cfgReg), 16'(expCfg));
      chk("R11 restart pulse count", 16'(restartCnt - rBefore), 16'(hit));
      chk("R11 convAbort low after stop", 16'(convAbort), 16'd0);
    end

    // R4 pointer-only write, then read follows it
    writeRegs("R4", 8'h02, 0, 8'h00, 8'h00);
    chk("R4 cfg unchanged", 16'(cfgReg), 16'h005A);
    chk("R4 hot unchanged", hotLimit, 16'h5000);
    chk("R4 hyst unchanged", hystLimit, 16'h4B00);
    readRegs("R4", 2, v);
    chk("R4 read follows pointer", v, 16'h4B00);

    // R6 single byte to a limit
    writeRegs("R6", 8'h03, 1, 8'h64, 8'h00);
    chk("R6 hot msb only", hotLimit, 16'h6400);
    writeRegs("R6b", 8'h03, 2, 8'h64, 8'h80);
    writeRegs("R6c", 8'h03, 1, 8'h70, 8'h00);
    chk("R6 low byte kept", hotLimit, 16'h7080);

    // R7 two bytes to a limit
    writeRegs("R7", 8'h02, 2, 8'h3C, 8'h80);
    chk("R7 hyst both bytes", hystLimit, 16'h3C80);

    // R5 configuration takes one byte only
    writeRegs("R5", 8'h01, 2, 8'hA5, 8'h11);
    chk("R5 cfg first byte", 16'(cfgReg), 16'h00A5);

    // R8 reads
    writeRegs("R8", 8'h00, 0, 8'h00, 8'h00);
    readRegs("R8 temp", 2, v);
    chk("R8 temperature hi then lo", v, 16'h1A80);
    writeRegs("R8", 8'h03, 0, 8'h00, 8'h00);
    readRegs("R8 hot", 2, v);
    chk("R8 hot hi then lo", v, 16'h7080);
    readRegs("R8 hot hi only", 1, v);
    chk("R8 hot single byte", v, 16'h0070);
    writeRegs("R8", 8'h01, 0, 8'h00, 8'h00);
    readRegs("R8 cfg", 1, v);
    chk("R8 cfg byte", v, 16'h00A5);

    // R10 unused pointer
    writeRegs("R10", 8'h07, 2, 8'h55, 8'h66);
    chk("R10 cfg unchanged", 16'(cfgReg), 16'h00A5);
    chk("R10 hot unchanged", hotLimit, 16'h7080);
    chk("R10 hyst unchanged", hystLimit, 16'h3C80);
    readRegs("R10", 2, v);
    chk("R10 reads zero", v, 16'h0000);

    // R12 start in the middle of a byte
    busStart();
    sendByte({DEV, 1'b0}, ack);
    clkBit(1'b0, s); clkBit(1'b1, s); clkBit(1'b0, s);
    busStart();
    sendByte({DEV, 1'b0}, ack); chk("R12 addr ack after restart", 16'(ack), 16'd1);
    sendByte(8'h01, ack);       chk("R12 ptr ack", 16'(ack), 16'd1);
    sendByte(8'h3E, ack);       chk("R12 data ack", 16'(ack), 16'd1);
    busStop();
    chk("R12 cfg written", 16'(cfgReg), 16'h003E);

    repeat (10) @(negedge clk);
    finishRun();
  end
endmodule